// File: doc/BRIEF.md
# Preamble and Frame Sync Hunter

This block watches a serial received-data stream, one bit per data strobe, and finds two things in turn: a run of alternating preamble bits, and then the frame synchronisation codeword that follows it. Both searches are correlations. The most recent bits are compared against the expected pattern, the mismatches are counted, and a hit is declared when the count is within a programmable error tolerance. The preamble and the codeword each have their own tolerance.

A second, programmable sync word can also be recognised. It marks the start of continuous data decoding rather than normal batch decoding. The block reports it with a one-clock pulse and a mode level that stays high.

Once any sync word is found, the block goes quiet. It hunts again only after a resync pulse or a reset. A protocol select input chooses whether a preamble must come before the sync word. While the decoder is switched off, the block ignores its data input.

Top module: `sync_hunter`

## Requirements
- R1: After reset, all four outputs are low and the block hunts for the preamble with an empty bit history.
- R2: While hunting the preamble, once at least 31 bits have been taken in since reset or resync, the last 31 bits are compared with an alternating 1/0 pattern in either phase. If they differ in no more than `pre_tol` positions, `pre_found` pulses for one clock, directly after the edge that samples the completing strobe. The hunt then moves on to the sync word.
- R3: While hunting the sync word, with at least 32 bits taken in, `sync_found` pulses for one clock when the last 32 bits differ from 32'h7CD215D8 in no more than `sync_tol` positions. The first bit received maps to bit 31. The block then locks.
- R4: A window whose error count exceeds the tolerance by one or more produces no detection, for both the preamble and the sync word.
- R5: A 32-bit window within `sync_tol` errors of `special_word` pulses `cont_found` for one clock, raises `cont_mode`, and locks the block. If a window matches both words, the standard codeword wins.
- R6: With `proto_sel` = 0, sync words are accepted only after a preamble has been found. With `proto_sel` = 1, they are also accepted while the block is still hunting the preamble. A sync hit takes priority over a preamble hit on the same bit.
- R7: While `dec_on` is low, strobes are ignored: the bit history and the bit count stay unchanged, and no pulse is produced.
- R8: While locked, no detection pulse occurs. A `resync` pulse returns the block to the preamble hunt, clears the bit count and `cont_mode`, and takes precedence over a strobe in the same cycle.
- R9: No detection is reported before enough bits have been taken in since reset or resync: 31 bits for the preamble, 32 bits for a sync word.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Asynchronous reset, active low |
| dec_on | input | 1 | Decoder operating; low means data is ignored |
| proto_sel | input | 1 | 0: preamble required before sync; 1: sync also hunted directly |
| pre_tol | input | 3 | Maximum preamble bit errors |
| sync_tol | input | 3 | Maximum sync word bit errors |
| special_word | input | 32 | Continuous-decode sync pattern |
| resync | input | 1 | Rearm pulse |
| bit_strobe | input | 1 | Data bit valid this clock |
| bit_in | input | 1 | Received data bit |
| pre_found | output | 1 | Preamble detected pulse |
| sync_found | output | 1 | Standard sync detected pulse |
| cont_found | output | 1 | Special sync detected pulse |
| cont_mode | output | 1 | Continuous decoding selected |

## Verification
A hunt state that is wrong shows up as a pulse that is missing or extra, directly after the strobe that completes a window. The only exception is a stuck lock, which stays hidden until the next full pattern arrives. A wrong bit history or bit count moves a detection by whole strobes, so the bench compares every clock cycle against a bit-exact model. Tolerance faults show up only at the exact boundary error counts, which the directed cases hit for both patterns.

// File: rtl/sync_hunter_pkg.sv
package sync_hunter_pkg;

    localparam logic [31:0] STD_SYNC_WORD = 32'h7CD2_15D8;

    typedef enum logic [1:0] {
        ST_PRE  = 2'd0,
        ST_SYNC = 2'd1,
        ST_LOCK = 2'd2
    } hunt_state_e;

    typedef struct packed {
        hunt_state_e st;
        logic        pre_p;
        logic        sync_p;
        logic        cont_p;
        logic        cont_m;
    } ctrl_state_t;

endpackage

// File: rtl/sh_window.sv
module sh_window #(
    parameter int unsigned WORD_W = 32,
    parameter int unsigned CNT_W  = 6
) (
    input  logic              clk,
    input  logic              rst_n,
    input  logic              shift_en,
    input  logic              clear,
    input  logic              bit_in,
    output logic [WORD_W-1:0] win_next,
    output logic [CNT_W-1:0]  fill_next
);
    localparam logic [CNT_W-1:0] FULL = CNT_W'(WORD_W);

    typedef struct packed {
        logic [WORD_W-1:0] win;
        logic [CNT_W-1:0]  fill;
    } win_t;

    win_t st_d, st_q;

    always_comb begin
        st_d = st_q;
        if (clear) begin
            st_d.fill = '0;
        end else if (shift_en) begin
            st_d.win = {st_q.win[WORD_W-2:0], bit_in};
            if (st_q.fill != FULL) begin
                st_d.fill = st_q.fill + 1'b1;
            end
        end
    end

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            st_q <= '0;
        end else begin
            st_q <= st_d;
        end
    end

    assign win_next  = st_d.win;
    assign fill_next = st_d.fill;
endmodule

// File: rtl/sh_corr.sv
module sh_corr #(
    parameter int unsigned W     = 32,
    parameter int unsigned TOL_W = 3
) (
    input  logic [W-1:0]     data,
    input  logic [W-1:0]     pattern,
    input  logic [TOL_W-1:0] tol,
    output logic             hit
);
    localparam int unsigned ERR_W = $clog2(W + 1);
    localparam int unsigned CMP_W = ERR_W + TOL_W;

    logic [W-1:0]     diff;
    logic [ERR_W-1:0] errs;

    assign diff = data ^ pattern;

    always_comb begin
        errs = '0;
        for (int i = 0; i < W; i++) begin
            errs = errs + ERR_W'(diff[i]);
        end
    end

    assign hit = (CMP_W'(errs) <= CMP_W'(tol));
endmodule

// File: rtl/sh_ctrl.sv
module sh_ctrl
    import sync_hunter_pkg::*;
#(
    parameter int unsigned WORD_W = 32,
    parameter int unsigned PRE_W  = 31,
    parameter int unsigned CNT_W  = 6
) (
    input  logic             clk,
    input  logic             rst_n,
    input  logic             dec_on,
    input  logic             strobe,
    input  logic             resync,
    input  logic             proto_sel,
    input  logic [CNT_W-1:0] fill_next,
    input  logic             pre_hit,
    input  logic             std_hit,
    input  logic             spc_hit,
    output logic             shift_en,
    output logic             clear,
    output logic             pre_found,
    output logic             sync_found,
    output logic             cont_found,
    output logic             cont_mode
);
    localparam logic [CNT_W-1:0] FULL    = CNT_W'(WORD_W);
    localparam logic [CNT_W-1:0] PRE_MIN = CNT_W'(PRE_W);

    ctrl_state_t c_d, c_q;
    logic sync_ok, pre_ok;

    assign shift_en = strobe & dec_on & ~resync;
    assign clear    = resync;

    always_comb begin
        c_d        = c_q;
        c_d.pre_p  = 1'b0;
        c_d.sync_p = 1'b0;
        c_d.cont_p = 1'b0;
        sync_ok    = 1'b0;
        pre_ok     = 1'b0;
        if (resync) begin
            c_d.st     = ST_PRE;
            c_d.cont_m = 1'b0;
        end else if (shift_en) begin
            sync_ok = (fill_next == FULL) &&
                      ((c_q.st == ST_SYNC) || ((c_q.st == ST_PRE) && proto_sel));
            pre_ok  = (c_q.st == ST_PRE) && (fill_next >= PRE_MIN);
            if (sync_ok && std_hit) begin
                c_d.sync_p = 1'b1;
                c_d.st     = ST_LOCK;
            end else if (sync_ok && spc_hit) begin
                c_d.cont_p = 1'b1;
                c_d.cont_m = 1'b1;
                c_d.st     = ST_LOCK;
            end else if (pre_ok && pre_hit) begin
                c_d.pre_p = 1'b1;
                c_d.st    = ST_SYNC;
            end
        end
    end

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            c_q <= '{st: ST_PRE, pre_p: 1'b0, sync_p: 1'b0, cont_p: 1'b0, cont_m: 1'b0};
        end else begin
            c_q <= c_d;
        end
    end

    assign pre_found  = c_q.pre_p;
    assign sync_found = c_q.sync_p;
    assign cont_found = c_q.cont_p;
    assign cont_mode  = c_q.cont_m;
endmodule

// File: rtl/sync_hunter.sv
module sync_hunter
    import sync_hunter_pkg::*;
#(
    parameter int unsigned WORD_W = 32,
    parameter int unsigned PRE_W  = 31,
    parameter int unsigned TOL_W  = 3
) (
    input  logic              clk,
    input  logic              rst_n,
    input  logic              dec_on,
    input  logic              proto_sel,
    input  logic [TOL_W-1:0]  pre_tol,
    input  logic [TOL_W-1:0]  sync_tol,
    input  logic [WORD_W-1:0] special_word,
    input  logic              resync,
    input  logic              bit_strobe,
    input  logic              bit_in,
    output logic              pre_found,
    output logic              sync_found,
    output logic              cont_found,
    output logic              cont_mode
);
    localparam int unsigned CNT_W = $clog2(WORD_W + 1);
    localparam logic [WORD_W-1:0] ALT_PAT = {(WORD_W / 2){2'b10}};
    localparam logic [PRE_W-1:0]  PRE_PAT = ALT_PAT[PRE_W-1:0];

    logic              shift_en, clear;
    logic [WORD_W-1:0] win_next;
    logic [CNT_W-1:0]  fill_next;
    logic [1:0]        phase_hit;
    logic              pre_hit, std_hit, spc_hit;

    sh_window #(.WORD_W(WORD_W), .CNT_W(CNT_W)) u_window (
        .clk       (clk),
        .rst_n     (rst_n),
        .shift_en  (shift_en),
        .clear     (clear),
        .bit_in    (bit_in),
        .win_next  (win_next),
        .fill_next (fill_next)
    );

    for (genvar ph = 0; ph < 2; ph++) begin : g_pre_phase
        localparam logic [PRE_W-1:0] PAT = (ph == 0) ? PRE_PAT : ~PRE_PAT;
        sh_corr #(.W(PRE_W), .TOL_W(TOL_W)) u_pre_corr (
            .data    (win_next[PRE_W-1:0]),
            .pattern (PAT),
            .tol     (pre_tol),
            .hit     (phase_hit[ph])
        );
    end
    assign pre_hit = |phase_hit;

    sh_corr #(.W(WORD_W), .TOL_W(TOL_W)) u_std_corr (
        .data    (win_next),
        .pattern (WORD_W'(STD_SYNC_WORD)),
        .tol     (sync_tol),
        .hit     (std_hit)
    );

    sh_corr #(.W(WORD_W), .TOL_W(TOL_W)) u_spc_corr (
        .data    (win_next),
        .pattern (special_word),
        .tol     (sync_tol),
        .hit     (spc_hit)
    );

    sh_ctrl #(.WORD_W(WORD_W), .PRE_W(PRE_W), .CNT_W(CNT_W)) u_ctrl (
        .clk        (clk),
        .rst_n      (rst_n),
        .dec_on     (dec_on),
        .strobe     (bit_strobe),
        .resync     (resync),
        .proto_sel  (proto_sel),
        .fill_next  (fill_next),
        .pre_hit    (pre_hit),
        .std_hit    (std_hit),
        .spc_hit    (spc_hit),
        .shift_en   (shift_en),
        .clear      (clear),
        .pre_found  (pre_found),
        .sync_found (sync_found),
        .cont_found (cont_found),
        .cont_mode  (cont_mode)
    );
endmodule

// File: rtl/sync_hunter_chk.sv
module sync_hunter_chk (
    input logic clk,
    input logic rst_n,
    input logic dec_on,
    input logic resync,
    input logic pre_found,
    input logic sync_found,
    input logic cont_found,
    input logic cont_mode
);
    // R6: a sync hit outranks a preamble hit, so at most one pulse per clock
    a_r6_single_pulse: assert property (@(posedge clk) disable iff (!rst_n)
        $onehot0({pre_found, sync_found, cont_found}));

    // R7: a cycle with the decoder off yields no pulse
    a_r7_off_quiet: assert property (@(posedge clk) disable iff (!rst_n)
        !dec_on |=> !(pre_found || sync_found || cont_found));

    // R8: locked after sync, nothing follows next clock
    a_r8_locked_quiet: assert property (@(posedge clk) disable iff (!rst_n)
        (sync_found || cont_found) |=> !(pre_found || sync_found || cont_found));

    // R8: resync clears continuous mode and suppresses pulses
    a_r8_resync_clears: assert property (@(posedge clk) disable iff (!rst_n)
        resync |=> (!cont_mode && !pre_found && !sync_found && !cont_found));

    // R5: continuous mode rises only with the special sync pulse
    a_r5_mode_rise: assert property (@(posedge clk) disable iff (!rst_n)
        $rose(cont_mode) |-> cont_found);

    // R5: the special pulse leaves the mode level set
    a_r5_mode_with_pulse: assert property (@(posedge clk) disable iff (!rst_n)
        cont_found |-> cont_mode);

    // R2: preamble pulse lasts one clock
    a_r2_one_clock: assert property (@(posedge clk) disable iff (!rst_n)
        pre_found |=> !pre_found);
endmodule

bind sync_hunter sync_hunter_chk u_chk (
    .clk        (clk),
    .rst_n      (rst_n),
    .dec_on     (dec_on),
    .resync     (resync),
    .pre_found  (pre_found),
    .sync_found (sync_found),
    .cont_found (cont_found),
    .cont_mode  (cont_mode)
);

// File: tb/sync_hunter_bench.sv
module sync_hunter_bench;
    logic        clk = 1'b0;
    logic        rst_n = 1'b0;
    logic        dec_on = 1'b1;
    logic        proto_sel = 1'b0;
    logic [2:0]  pre_tol = 3'd4;
    logic [2:0]  sync_tol = 3'd2;
    logic [31:0] special_word = 32'h3B8E_94C1;
    logic        resync = 1'b0;
    logic        bit_strobe = 1'b0;
    logic        bit_in = 1'b0;
    logic        pre_found, sync_found, cont_found, cont_mode;

    localparam logic [31:0] STD = 32'h7CD2_15D8;
    localparam logic [30:0] ALT = 31'h2AAA_AAAA;

    always #4 clk = ~clk;

    sync_hunter u_sync_hunter (
        .clk(clk), .rst_n(rst_n), .dec_on(dec_on), .proto_sel(proto_sel),
        .pre_tol(pre_tol), .sync_tol(sync_tol), .special_word(special_word),
        .resync(resync), .bit_strobe(bit_strobe), .bit_in(bit_in),
        .pre_found(pre_found), .sync_found(sync_found),
        .cont_found(cont_found), .cont_mode(cont_mode)
    );

    int    n_vec = 0;
    int    n_bad = 0;
    bit    done = 1'b0;
    string cur_req = "R1";

    logic [31:0] m_sh = '0;
    int          m_fill = 0;
    int          m_st = 0;      // 0 preamble hunt, 1 sync hunt, 2 locked
    bit          m_cont = 1'b0;
    bit          e_pre, e_sync, e_cpl;

    function automatic int pop32(logic [31:0] v);
        int n = 0;
        for (int i = 0; i < 32; i++) n += int'(v[i]);
        return n;
    endfunction

    function automatic int min2(int a, int b);
        return (a < b) ? a : b;
    endfunction

    task automatic model_edge(bit stb, bit b, bit rs);
        bit sync_ok, std_ok, spc_ok, pre_ok;
        e_pre = 0; e_sync = 0; e_cpl = 0;
        if (rs) begin
            m_st = 0; m_fill = 0; m_cont = 0;
        end else if (stb && dec_on) begin
            m_sh = {m_sh[30:0], b};
            if (m_fill < 32) m_fill++;
            sync_ok = (m_fill >= 32) && (m_st == 1 || (m_st == 0 && proto_sel));
            std_ok  = sync_ok && pop32(m_sh ^ STD) <= int'(sync_tol);
            spc_ok  = sync_ok && !std_ok && pop32(m_sh ^ special_word) <= int'(sync_tol);
            pre_ok  = (m_st == 0) && !std_ok && !spc_ok && (m_fill >= 31) &&
                      min2(pop32({1'b0, m_sh[30:0] ^ ALT}), pop32({1'b0, m_sh[30:0] ^ ~ALT})) <= int'(pre_tol);
            if (std_ok) begin e_sync = 1; m_st = 2; end
            else if (spc_ok) begin e_cpl = 1; m_cont = 1; m_st = 2; end
            else if (pre_ok) begin e_pre = 1; m_st = 1; end
        end
    endtask

    task automatic compare();
        n_vec++;
        if ({pre_found, sync_found, cont_found, cont_mode} !== {e_pre, e_sync, e_cpl, m_cont}) begin
            n_bad++;
            $display("FAIL %s: pre/sync/cont/mode got %b%b%b%b expected %b%b%b%b at %0t",
                     cur_req, pre_found, sync_found, cont_found, cont_mode,
                     e_pre, e_sync, e_cpl, m_cont, $time);
        end
    endtask

    // called at a negative edge; drives, lets one rising edge pass, checks
    task automatic step(bit stb, bit b, bit rs);
        bit_strobe = stb; bit_in = b; resync = rs;
        model_edge(stb, b, rs);
        @(negedge clk);
        compare();
        bit_strobe = 0; resync = 0;
    endtask

    task automatic send_word(logic [31:0] w, int nbits);
        for (int i = nbits - 1; i >= 0; i--) step(1'b1, w[i], 1'b0);
    endtask

    function automatic logic [31:0] flip_n(logic [31:0] w, int n, int width);
        logic [31:0] r = w;
        int cnt = 0;
        while (cnt < n) begin
            int p = int'($urandom_range(width - 1, 0));
            if (r[p] == w[p]) begin r[p] = ~r[p]; cnt++; end
        end
        return r;
    endfunction

    task automatic summary();
        $display("  == %0d vectors applied, %0d miscompares ==", n_vec, n_bad);
    endtask

    initial begin
        repeat (200000) @(posedge clk);
        if (!done) begin
            n_bad++;
            $display("FAIL watchdog: got hung run expected completion");
            summary();
            $finish;
        end
    end

    initial begin
        void'($urandom(32'd2417));
        repeat (3) @(negedge clk);
        cur_req = "R1";
        e_pre = 0; e_sync = 0; e_cpl = 0;
        compare();
        rst_n = 1'b1;
        @(negedge clk);
        compare();

        cur_req = "R9";                         // 30 bits: too few
        send_word({1'b0, ALT}, 30);
        cur_req = "R2";                         // 31st completes the window
        step(1'b1, 1'b0, 1'b0);
        cur_req = "R3";                         // two errors allowed
        send_word(flip_n(STD, 2, 32), 32);
        cur_req = "R8";
        send_word({1'b1, ALT}, 32);
        send_word(STD, 32);
        step(1'b0, 1'b0, 1'b1);

        cur_req = "R4";                         // preamble with 5 errors
        send_word({1'b0, flip_n({1'b0, ALT}, 5, 31)}, 31);
        step(1'b0, 1'b0, 1'b1);
        cur_req = "R2";                         // other phase, 4 errors
        send_word({1'b0, flip_n({1'b0, ~ALT}, 4, 31)}, 31);
        cur_req = "R4";                         // sync with 3 errors
        send_word(flip_n(STD, 3, 32), 32);
        cur_req = "R3";
        send_word(STD, 32);

        cur_req = "R5";
        step(1'b0, 1'b0, 1'b1);
        send_word({1'b0, ALT}, 31);
        send_word(flip_n(special_word, 1, 32), 32);
        repeat (5) step(1'b0, 1'b0, 1'b0);
        cur_req = "R8";
        step(1'b1, 1'b1, 1'b1);                 // resync beats strobe

        cur_req = "R6";
        send_word(STD, 32);                     // no preamble, mode 0
        proto_sel = 1'b1;
        step(1'b0, 1'b0, 1'b1);
        send_word(STD, 32);                     // mode 1 accepts directly
        proto_sel = 1'b0;

        cur_req = "R7";
        step(1'b0, 1'b0, 1'b1);
        send_word({1'b0, ALT}, 20);
        dec_on = 1'b0;
        send_word(32'hFFFF_FFFF, 16);
        dec_on = 1'b1;
        send_word({1'b0, ALT}, 11);

        for (int it = 0; it < 2500; it++) begin
            int kind = int'($urandom_range(9, 0));
            if (it % 100 == 0) begin
                proto_sel = 1'($urandom_range(1, 0));
                pre_tol   = 3'($urandom_range(5, 0));
                sync_tol  = 3'($urandom_range(3, 0));
            end
            dec_on = ($urandom_range(15, 0) != 0);
            if (kind == 0) begin
                cur_req = "R2";
                send_word({1'b0, flip_n({1'b0, ALT}, int'($urandom_range(6, 0)), 31)}, 31);
            end else if (kind == 1) begin
                cur_req = "R3";
                send_word(flip_n(STD, int'($urandom_range(4, 0)), 32), 32);
            end else if (kind == 2) begin
                cur_req = "R5";
                send_word(flip_n(special_word, int'($urandom_range(4, 0)), 32), 32);
            end else if (kind == 3) begin
                cur_req = "R8";
                step(1'b1, 1'($urandom_range(1, 0)), 1'($urandom_range(3, 0) == 0));
            end else begin
                cur_req = "R9";
                step(1'($urandom_range(3, 0) != 0), 1'($urandom_range(1, 0)), 1'b0);
            end
        end

        done = 1'b1;
        summary();
        $finish;
    end
endmodule